// File: doc/BRIEF.md
# Byte-Stream DMA Engine for a Disk Controller

This block moves a run of bytes between a disk controller and system memory so that the host processor takes no part in the transfer itself. The host sees only two bus locations. Offset 1 is written to choose one of the internal registers and is read to get a status byte. Offset 0 is a data port that reads or writes whichever register was last chosen. Behind the data port sit a control byte, a 16-bit memory address loaded one byte at a time, a 16-bit length loaded one byte at a time as the ones' complement of the byte count, and a command byte that is passed on to the disk controller.

The host loads the address and the complemented length, then writes the control byte with its start bit set. From then on the engine waits for the controller's byte request, exchanges the byte with memory through a request/grant handshake, and advances both the address and the length counter by one. When the counter reaches all ones the transfer is over. The engine then flags a pending completion, and that flag drives the interrupt line if the control byte enables it.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset the status byte reads 00, and `irq`, `mem_req` and `dsk_ack` are low.
- R2: A write at offset 1 loads the register pointer. A read or write at offset 0 reaches the register the pointer selects: 00 control, 02 address bits 7:0, 04 address bits 15:8, 06 count bits 7:0, 08 count bits 15:8, 0A command. A pointer value outside this set reads as 00 and ignores writes.
- R3: A read at offset 1 returns the status byte, with bit 0 set while a transfer is in progress and bit 7 set while a completion is pending. That read clears the pending flag.
- R4: A count loaded as the ones' complement of N moves exactly N bytes and leaves the count at FFFF. A start given with the count already at FFFF moves no byte and sets the pending flag at once.
- R5: When control bit 1 is 0, each byte taken from the disk on `dsk_ack` is written to memory (`mem_we` high) at the current address. The address then increments across the full 16 bits.
- R6: When control bit 1 is 1, each byte is read from memory at the current address and then presented on `dsk_wdata` while `dsk_ack` is high.
- R7: `mem_req` stays high with a stable address until `mem_gnt` arrives. Each grant moves exactly one byte, and `mem_req` drops in the cycle after a grant.
- R8: The end of a transfer sets the pending flag. `irq` is high only while the flag is set and control bit 7 is 1.
- R9: While a transfer is in progress, writes to the control, address and count registers have no effect.
- R10: A write to the command register updates `ctl_cmd` and pulses `ctl_cmd_wr` for exactly one cycle.
- R11: `dsk_ack` is high only in a cycle in which `dsk_drq` is high and a transfer is in progress. Control bit 0 starts a transfer and always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs | input | 1 | Host access in this cycle |
| host_we | input | 1 | Host write (1) or read (0) |
| host_a | input | 1 | 0 = data port, 1 = pointer on write / status on read |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory cycle request |
| mem_gnt | input | 1 | Memory grant, one byte per grant |
| mem_we | output | 1 | Memory write (disk to memory) |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Byte written to memory |
| mem_rdata | input | 8 | Byte read from memory |
| dsk_drq | input | 1 | Controller is ready for a byte |
| dsk_ack | output | 1 | Byte accepted or presented this cycle |
| dsk_rdata | input | 8 | Byte from the controller |
| dsk_wdata | output | 8 | Byte to the controller |
| ctl_cmd | output | 8 | Command byte for the controller |
| ctl_cmd_wr | output | 1 | One-cycle strobe after a command write |

## Verification
The assertions watch several rules on every cycle: the request hold and single-byte-per-grant rule of the memory handshake, the frozen address during a transfer outside the stepping cycles, the all-ones count at every transfer end, the pointer load, the command strobe, and the clearing and setting of the pending flag. Only the bench's scenarios can show the rest. That covers the exact byte sequence and addresses in each direction, the carry of the address across a byte boundary, the exact number of bytes moved for a given complemented length, the zero-length start, and the interrupt gating. It also covers the refusal of register writes during a transfer, which the bench sees by reading the registers back and by the interrupt still arriving.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_DSK  = 2'd1,
        XS_MEM  = 2'd2
    } xfer_st_e;

    localparam logic [7:0] RA_CTRL = 8'h00;
    localparam logic [7:0] RA_ALO  = 8'h02;
    localparam logic [7:0] RA_AHI  = 8'h04;
    localparam logic [7:0] RA_CLO  = 8'h06;
    localparam logic [7:0] RA_CHI  = 8'h08;
    localparam logic [7:0] RA_CMD  = 8'h0A;

    localparam int CB_START = 0;
    localparam int CB_DIR   = 1;
    localparam int CB_IEN   = 7;

    typedef struct packed {
        logic ctrl;
        logic alo;
        logic ahi;
        logic clo;
        logic chi;
    } wr_sel_t;
endpackage

// File: rtl/dmx_host_if.sv
module dmx_host_if
    import dmx_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic              host_a,
    input  logic [7:0]        host_wdata,
    input  logic [7:0]        ctrl_rd,
    input  logic [ADDR_W-1:0] addr_rd,
    input  logic [CNT_W-1:0]  cnt_rd,
    input  logic [7:0]        status_rd,
    output logic [7:0]        host_rdata,
    output wr_sel_t           wr_sel,
    output logic              rd_status,
    output logic [7:0]        cmd_o,
    output logic              cmd_wr_o
);
    typedef struct packed {
        logic [7:0] ptr;
        logic [7:0] cmd;
        logic       cmd_wr;
    } hif_t;

    hif_t s_d, s_q;
    logic wr_data;

    always_comb begin
        s_d        = s_q;
        s_d.cmd_wr = 1'b0;
        wr_sel     = '0;
        wr_data    = host_cs && host_we && !host_a;
        rd_status  = host_cs && !host_we && host_a;
        if (host_cs && host_we && host_a) begin
            s_d.ptr = host_wdata;
        end
        if (wr_data) begin
            unique case (s_q.ptr)
                RA_CTRL: wr_sel.ctrl = 1'b1;
                RA_ALO:  wr_sel.alo  = 1'b1;
                RA_AHI:  wr_sel.ahi  = 1'b1;
                RA_CLO:  wr_sel.clo  = 1'b1;
                RA_CHI:  wr_sel.chi  = 1'b1;
                RA_CMD: begin
                    s_d.cmd    = host_wdata;
                    s_d.cmd_wr = 1'b1;
                end
                default: ;
            endcase
        end
        if (host_a) begin
            host_rdata = status_rd;
        end else begin
            unique case (s_q.ptr)
                RA_CTRL: host_rdata = ctrl_rd;
                RA_ALO:  host_rdata = addr_rd[7:0];
                RA_AHI:  host_rdata = 8'(addr_rd[ADDR_W-1:8]);
                RA_CLO:  host_rdata = cnt_rd[7:0];
                RA_CHI:  host_rdata = 8'(cnt_rd[CNT_W-1:8]);
                RA_CMD:  host_rdata = s_q.cmd;
                default: host_rdata = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_o    = s_q.cmd;
    assign cmd_wr_o = s_q.cmd_wr;

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_we && host_a) |=> (s_q.ptr == $past(host_wdata)));

    // R10
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_o |=> !cmd_wr_o || $past(wr_data));
endmodule

// File: rtl/dmx_xfer.sv
module dmx_xfer
    import dmx_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_sel_t           wr_sel,
    input  logic [7:0]        wdata,
    input  logic              mem_gnt,
    input  logic [7:0]        mem_rdata,
    input  logic              dsk_drq,
    input  logic [7:0]        dsk_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              dsk_ack,
    output logic [7:0]        dsk_wdata,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [7:0]        ctrl_o,
    output logic              busy,
    output logic              done
);
    localparam int AHI_W = ADDR_W - 8;
    localparam int CHI_W = CNT_W - 8;
    localparam logic [CNT_W-1:0] CNT_END = {CNT_W{1'b1}};

    typedef struct packed {
        xfer_st_e          st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [7:0]        ctrl;
        logic [7:0]        dbuf;
        logic              done;
    } xf_t;

    xf_t s_d, s_q;
    logic step;
    logic dir;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        step     = 1'b0;
        dir      = s_q.ctrl[CB_DIR];
        cnt_nx   = s_q.cnt + CNT_W'(1);
        unique case (s_q.st)
            XS_IDLE: begin
                if (wr_sel.alo) s_d.addr[7:0]        = wdata;
                if (wr_sel.ahi) s_d.addr[ADDR_W-1:8] = AHI_W'(wdata);
                if (wr_sel.clo) s_d.cnt[7:0]         = wdata;
                if (wr_sel.chi) s_d.cnt[CNT_W-1:8]   = CHI_W'(wdata);
                if (wr_sel.ctrl) begin
                    s_d.ctrl = wdata & ~(8'h01 << CB_START);
                    if (wdata[CB_START]) begin
                        if (s_q.cnt == CNT_END) s_d.done = 1'b1;
                        else if (wdata[CB_DIR]) s_d.st = XS_MEM;
                        else                    s_d.st = XS_DSK;
                    end
                end
            end
            XS_DSK: begin
                if (dsk_drq) begin
                    if (dir) begin
                        step = 1'b1;
                    end else begin
                        s_d.dbuf = dsk_rdata;
                        s_d.st   = XS_MEM;
                    end
                end
            end
            XS_MEM: begin
                if (mem_gnt) begin
                    if (dir) begin
                        s_d.dbuf = mem_rdata;
                        s_d.st   = XS_DSK;
                    end else begin
                        step = 1'b1;
                    end
                end
            end
            default: s_d.st = XS_IDLE;
        endcase
        if (step) begin
            s_d.addr = s_q.addr + ADDR_W'(1);
            s_d.cnt  = cnt_nx;
            if (cnt_nx == CNT_END) begin
                s_d.st   = XS_IDLE;
                s_d.done = 1'b1;
            end else begin
                s_d.st = dir ? XS_MEM : XS_DSK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= XS_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_req   = (s_q.st == XS_MEM);
    assign mem_we    = !s_q.ctrl[CB_DIR];
    assign mem_addr  = s_q.addr;
    assign mem_wdata = s_q.dbuf;
    assign dsk_wdata = s_q.dbuf;
    assign dsk_ack   = (s_q.st == XS_DSK) && dsk_drq;
    assign cnt_o     = s_q.cnt;
    assign ctrl_o    = s_q.ctrl;
    assign busy      = (s_q.st != XS_IDLE);
    assign done      = s_q.done;

    // R7
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    // R7
    one_per_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> !mem_req);

    // R9
    busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(mem_req && mem_gnt) && !dsk_ack) |=> ($stable(mem_addr) && $stable(cnt_o)));

    // R4
    end_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cnt_o == CNT_END));
endmodule

// File: rtl/dmx_irq.sv
module dmx_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic ien_i,
    output logic pend_o,
    output logic irq_o
);
    typedef struct packed {
        logic pend;
    } irq_t;

    irq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) s_d.pend = 1'b0;
        if (set_i) s_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_o = s_q.pend;
    assign irq_o  = s_q.pend && ien_i;

    // R3
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_o);

    // R8
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o);
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dmx_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic              host_a,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              irq,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              dsk_drq,
    output logic              dsk_ack,
    input  logic [7:0]        dsk_rdata,
    output logic [7:0]        dsk_wdata,
    output logic [7:0]        ctl_cmd,
    output logic              ctl_cmd_wr
);
    wr_sel_t          wr_sel;
    logic             rd_status;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       ctrl;
    logic             busy;
    logic             done;
    logic             pend;
    logic [7:0]       status;

    assign status = {pend, 6'b0, busy};

    dmx_host_if #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_cs    (host_cs),
        .host_we    (host_we),
        .host_a     (host_a),
        .host_wdata (host_wdata),
        .ctrl_rd    (ctrl),
        .addr_rd    (mem_addr),
        .cnt_rd     (cnt),
        .status_rd  (status),
        .host_rdata (host_rdata),
        .wr_sel     (wr_sel),
        .rd_status  (rd_status),
        .cmd_o      (ctl_cmd),
        .cmd_wr_o   (ctl_cmd_wr)
    );

    dmx_xfer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel    (wr_sel),
        .wdata     (host_wdata),
        .mem_gnt   (mem_gnt),
        .mem_rdata (mem_rdata),
        .dsk_drq   (dsk_drq),
        .dsk_rdata (dsk_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .dsk_ack   (dsk_ack),
        .dsk_wdata (dsk_wdata),
        .cnt_o     (cnt),
        .ctrl_o    (ctrl),
        .busy      (busy),
        .done      (done)
    );

    dmx_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (done),
        .clr_i  (rd_status),
        .ien_i  (ctrl[CB_IEN]),
        .pend_o (pend),
        .irq_o  (irq)
    );

    // R11
    ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsk_ack |-> (dsk_drq && status[0]));
endmodule

// File: tb/dma_xfer_engine_bench.sv
`timescale 1ns/1ps
module dma_xfer_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs = 1'b0, host_we = 1'b0, host_a = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        irq, mem_req, mem_we, dsk_ack, ctl_cmd_wr;
    logic        mem_gnt = 1'b0, dsk_drq = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata, dsk_rdata, dsk_wdata, ctl_cmd;

    int checks = 0, errors = 0;
    logic [23:0] exp_q[$];
    bit  drq_en = 1'b1, gnt_slow = 1'b0, mode_dir = 1'b0;
    int  disk_idx = 0;

    function automatic logic [7:0] dsrc(int k);
        return 8'(k * 7 + 3);
    endfunction
    function automatic logic [7:0] memf(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign mem_rdata = memf(mem_addr);
    assign dsk_rdata = dsrc(disk_idx);

    always #4 clk = ~clk;

    dma_xfer_engine u_dma_xfer_engine (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
        .host_a(host_a), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dsk_drq(dsk_drq), .dsk_ack(dsk_ack), .dsk_rdata(dsk_rdata),
        .dsk_wdata(dsk_wdata), .ctl_cmd(ctl_cmd), .ctl_cmd_wr(ctl_cmd_wr)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // memory grant model
    initial begin
        bit stall = 1'b0;
        forever begin
            @(posedge clk); #2;
            stall   = ~stall;
            mem_gnt = mem_req && !mem_gnt && (!gnt_slow || stall);
        end
    end

    // disk request model
    initial begin
        bit ack_seen;
        bit ph = 1'b0;
        forever begin
            @(negedge clk);
            ack_seen = dsk_ack;
            @(posedge clk); #2;
            if (ack_seen) disk_idx++;
            ph      = ~ph;
            dsk_drq = drq_en && ph;
        end
    end

    // scoreboard monitor
    initial begin
        logic [23:0] it;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req && mem_gnt && mem_we) begin
                if (exp_q.size() == 0) chk(1'b0, "R4 extra mem write", int'(mem_addr), 0);
                else begin
                    it = exp_q.pop_front();
                    chk({mem_addr, mem_wdata} == it, "R5 mem write", int'({mem_addr, mem_wdata}), int'(it));
                end
            end
            if (rst_n && dsk_ack && mode_dir) begin
                if (exp_q.size() == 0) chk(1'b0, "R4 extra disk byte", int'(dsk_wdata), 0);
                else begin
                    it = exp_q.pop_front();
                    chk(dsk_wdata == it[7:0], "R6 disk byte", int'(dsk_wdata), int'(it[7:0]));
                end
            end
        end
    end

    task automatic host_wr(bit a, logic [7:0] d);
        @(posedge clk); #2;
        host_cs = 1'b1; host_we = 1'b1; host_a = a; host_wdata = d;
        @(posedge clk); #2;
        host_cs = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_rd(bit a, output logic [7:0] d);
        @(posedge clk); #2;
        host_cs = 1'b1; host_we = 1'b0; host_a = a;
        @(negedge clk);
        d = host_rdata;
        @(posedge clk); #2;
        host_cs = 1'b0;
    endtask

    task automatic setreg(logic [7:0] p, logic [7:0] d);
        host_wr(1'b1, p);
        host_wr(1'b0, d);
    endtask

    task automatic getreg(logic [7:0] p, output logic [7:0] d);
        host_wr(1'b1, p);
        host_rd(1'b0, d);
    endtask

    task automatic start_xfer(bit dir, logic [15:0] a, int n, bit ien);
        logic [15:0] c;
        mode_dir = dir;
        for (int k = 0; k < n; k++) begin
            if (dir) exp_q.push_back({16'h0, memf(a + 16'(k))});
            else     exp_q.push_back({a + 16'(k), dsrc(disk_idx + k)});
        end
        c = ~16'(n);
        setreg(8'h02, a[7:0]);
        setreg(8'h04, a[15:8]);
        setreg(8'h06, c[7:0]);
        setreg(8'h08, c[15:8]);
        setreg(8'h00, {ien, 5'b0, dir, 1'b1});
    endtask

    task automatic wait_irq(string req);
        int t = 0;
        while (!irq && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(irq === 1'b1, req, int'(irq), 1);
    endtask

    task automatic post_check(logic [15:0] end_addr);
        logic [7:0] v, lo, hi;
        chk(exp_q.size() == 0, "R4 bytes left", exp_q.size(), 0);
        getreg(8'h02, lo); getreg(8'h04, hi);
        chk({hi, lo} == end_addr, "R5 final address", int'({hi, lo}), int'(end_addr));
        getreg(8'h06, lo); getreg(8'h08, hi);
        chk({hi, lo} == 16'hFFFF, "R4 final count", int'({hi, lo}), 'hFFFF);
        host_rd(1'b1, v);
        chk(v == 8'h80, "R3 status after end", int'(v), 'h80);
        @(negedge clk);
        chk(irq == 1'b0, "R3 irq cleared by status read", int'(irq), 0);
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        host_rd(1'b1, v);
        chk(v == 8'h00, "R1 status", int'(v), 0);
        chk(irq == 1'b0 && mem_req == 1'b0 && dsk_ack == 1'b0, "R1 outputs idle",
            int'({irq, mem_req, dsk_ack}), 0);

        // R2 register readback
        setreg(8'h02, 8'h34); getreg(8'h02, v);
        chk(v == 8'h34, "R2 addr low", int'(v), 'h34);
        setreg(8'h04, 8'h12); getreg(8'h04, v);
        chk(v == 8'h12, "R2 addr high", int'(v), 'h12);
        setreg(8'h06, 8'hAA); getreg(8'h06, v);
        chk(v == 8'hAA, "R2 count low", int'(v), 'hAA);
        setreg(8'h08, 8'h55); getreg(8'h08, v);
        chk(v == 8'h55, "R2 count high", int'(v), 'h55);
        setreg(8'h0C, 8'h77); getreg(8'h0C, v);
        chk(v == 8'h00, "R2 unmapped pointer", int'(v), 0);
        setreg(8'h00, 8'h80); getreg(8'h00, v);
        chk(v == 8'h80, "R2 control readback", int'(v), 'h80);

        // R10 command strobe
        host_wr(1'b1, 8'h0A);
        host_wr(1'b0, 8'h9C);
        @(negedge clk);
        chk(ctl_cmd_wr == 1'b1 && ctl_cmd == 8'h9C, "R10 strobe high",
            int'({ctl_cmd_wr, ctl_cmd}), 'h19C);
        @(negedge clk);
        chk(ctl_cmd_wr == 1'b0, "R10 strobe one cycle", int'(ctl_cmd_wr), 0);

        // R5 disk to memory, five bytes
        start_xfer(1'b0, 16'h1000, 5, 1'b1);
        getreg(8'h00, v);
        chk(v == 8'h80, "R11 start bit reads zero", int'(v), 'h80);
        wait_irq("R8 irq after disk-to-memory");
        post_check(16'h1005);

        // R6 memory to disk, crossing a byte boundary, slow grants for R7
        gnt_slow = 1'b1;
        start_xfer(1'b1, 16'h20FE, 4, 1'b1);
        wait_irq("R8 irq after memory-to-disk");
        post_check(16'h2102);
        gnt_slow = 1'b0;

        // R9 writes ignored while busy
        drq_en = 1'b0;
        start_xfer(1'b0, 16'h3000, 3, 1'b1);
        host_rd(1'b1, v);
        chk(v == 8'h01, "R3 busy bit", int'(v), 1);
        setreg(8'h02, 8'hEE); getreg(8'h02, v);
        chk(v == 8'h00, "R9 addr write ignored", int'(v), 0);
        setreg(8'h06, 8'h00); getreg(8'h06, v);
        chk(v == 8'hFC, "R9 count write ignored", int'(v), 'hFC);
        setreg(8'h00, 8'h00);
        drq_en = 1'b1;
        wait_irq("R9 control write ignored, irq still enabled");
        post_check(16'h3003);

        // R4 zero-length start
        setreg(8'h06, 8'hFF);
        setreg(8'h08, 8'hFF);
        setreg(8'h00, 8'h81);
        repeat (3) @(negedge clk);
        chk(irq == 1'b1, "R4 immediate completion", int'(irq), 1);
        host_rd(1'b1, v);
        chk(v == 8'h80, "R4 zero-length status", int'(v), 'h80);
        chk(exp_q.size() == 0, "R4 no bytes moved", exp_q.size(), 0);

        // R8 interrupt disabled
        start_xfer(1'b0, 16'h4000, 2, 1'b0);
        repeat (200) @(negedge clk);
        chk(irq == 1'b0, "R8 irq masked", int'(irq), 0);
        host_rd(1'b1, v);
        chk(v == 8'h80, "R8 pending without irq", int'(v), 'h80);
        chk(exp_q.size() == 0, "R4 masked transfer complete", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule